// File: doc/BRIEF.md
# Snoop Responder for PCI Memory Reads

This block sits between the PCI target path and a small L1 data cache model. Each memory read that PCI makes is offered to the block over a valid/ready request channel. The block turns that request into a one-cycle command on an internal snoop bus, looks up the addressed line in a direct-mapped tag and state array, and decides what the cache must do about the external read. The array holds 16 lines of 32 bytes, and each line is invalid, exclusive or modified. The address splits into a 5-bit offset, a 4-bit index and a 23-bit tag.

A snooped read is treated as if it were a write. Any hit therefore ends with the line invalidated. A modified line is first pushed to memory as a four-beat burst of 64-bit words on a valid/ready write-back port. Only one snoop runs at a time. `req_ready` is low from the accepting edge until the snoop is over, and `retry` stays high during a write-back so that the PCI side holds off. A completion pulse `done` ends every request. A test port preloads tags, states and data and reads back the tag and state of a line.

Back-pressure rules: a request moves on the edge where `req_valid` and `req_ready` are both high. A write-back beat moves on the edge where `wb_valid` and `wb_ready` are both high. Once `wb_valid` is raised, it and the beat's address, data and last flag hold until that beat is taken.

Top module: `snoop_responder`

## Requirements
- R1: After reset `req_ready` is 1, `snp_valid`, `done`, `retry` and `wb_valid` are 0, and every line reads back as state 2'b00 (invalid).
- R2: A request is accepted on an edge with `req_valid` and `req_ready` high. `req_ready` is then 0 until the cycle after `done`, and it is 0 whenever `retry` is 1.
- R3: An accepted request with `req_lock`=0 and snooping enabled drives `snp_valid`=1 for exactly the next cycle. In that cycle `snp_kind`=2'b01 (plain read), `snp_addr` equals the request address and `snp_flush` equals `req_burst`.
- R4: An accepted request with `req_lock`=1 and snooping enabled drives `snp_kind`=2'b10 (atomic read-with-intent-to-modify) in that snoop cycle. The state outcome is the same as for an unlocked read.
- R5: If `snoop_en` is 0 on the accepting edge, `snp_valid` stays 0 and `done` pulses in the next cycle. No write-back occurs and no line state changes.
- R6: A snoop whose line is invalid or whose tag differs completes with `done` in the snoop cycle, with no write-back and no state change.
- R7: A snoop that hits an exclusive line (state 2'b01) completes with `done` in the snoop cycle, with no write-back, and leaves the line invalid.
- R8: A snoop that hits a modified line (state 2'b10) writes 4 beats, with beat b at address {tag, index, b, 3'b000} and carrying that line's data word b, and `wb_last` set on beat 3. `retry` is high from the cycle after the snoop cycle until the last beat is taken. `done` is high in the cycle of the last handshake, and the line is invalid after it.
- R9: While `wb_valid` is 1 and `wb_ready` is 0, the next cycle keeps `wb_valid`=1 with `wb_addr`, `wb_data` and `wb_last` unchanged.
- R10: `done` is never high in two consecutive cycles, and each accepted request produces exactly one `done`.
- R11: With `tp_we`=1, the tag and state on the test port are written to line `tp_index`. With `tp_dwe`=1, `tp_data` is written to word `tp_beat` of that line. `tp_rd_tag` and `tp_rd_state` show line `tp_index` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snoop_en | input | 1 | Snooping enable, sampled when a request is accepted |
| req_valid | input | 1 | PCI memory read request present |
| req_ready | output | 1 | Responder idle and able to take a request |
| req_addr | input | 32 | Request byte address |
| req_burst | input | 1 | Request is a burst read |
| req_lock | input | 1 | Request is a locked read |
| snp_valid | output | 1 | Snoop command on the internal bus |
| snp_kind | output | 2 | 01 read, 10 atomic read-with-intent-to-modify |
| snp_addr | output | 32 | Snooped address |
| snp_flush | output | 1 | Snoop treated as a write (burst read) |
| done | output | 1 | One-cycle completion pulse |
| retry | output | 1 | PCI side must stall; write-back in progress |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | Memory takes the beat |
| wb_addr | output | 32 | Write-back beat address |
| wb_data | output | 64 | Write-back beat data |
| wb_last | output | 1 | Final beat of the line |
| tp_we | input | 1 | Test write of tag and state |
| tp_dwe | input | 1 | Test write of one data word |
| tp_index | input | 4 | Test line index, for writes and read-back |
| tp_beat | input | 2 | Test data word select |
| tp_tag | input | 23 | Test tag value |
| tp_state | input | 2 | Test state value |
| tp_data | input | 64 | Test data word |
| tp_rd_tag | output | 23 | Tag of line `tp_index` |
| tp_rd_state | output | 2 | State of line `tp_index` |

## Verification
Some rules are checked on every cycle: the mapping from request flags to snoop command, the silence of the snoop bus when snooping is off, the busy interlock between `retry` and `req_ready`, the holding of a stalled write-back beat, the single-cycle `done`, and the rule that a write-back only happens while `retry` is high. Other behaviour can only be seen in the bench's scenarios. This covers the state each line ends in after a snoop on invalid, exclusive, modified and mismatched-tag lines; the order, addresses and data of the write-back beats under random memory stalls; and the fact that a disabled snoop leaves a modified line untouched.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    ST_INV  = 2'b00,
    ST_EXCL = 2'b01,
    ST_MOD  = 2'b10
  } line_st_e;

  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_RWITM = 2'b10;

  typedef enum logic [1:0] {
    F_IDLE  = 2'b00,
    F_LOOK  = 2'b01,
    F_FLUSH = 2'b10
  } fsm_e;
endpackage

// File: rtl/snp_cmd_map.sv
module snp_cmd_map
  import snp_pkg::*;
(
  input  logic       lock_i,
  input  logic       burst_i,
  output logic [1:0] kind_o,
  output logic       as_write_o
);
  // Locked reads become atomic intent-to-modify; bursts are write-like.
  always_comb begin
    kind_o     = lock_i ? KIND_RWITM : KIND_READ;
    as_write_o = burst_i;
  end
endmodule

// File: rtl/snp_beat_ctr.sv
module snp_beat_ctr #(
  parameter int BEATS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      adv_i,
  output logic [$clog2(BEATS)-1:0]  beat_o,
  output logic                      last_o
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beat_o <= '0;
    else if (clr_i)  beat_o <= '0;
    else if (adv_i)  beat_o <= beat_o + 1'b1;
  end

  assign last_o = (beat_o == LAST);
endmodule

// File: rtl/snp_line_store.sv
module snp_line_store
  import snp_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int TAG_W  = 23,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(LINES)-1:0]  lk_idx_i,
  output logic [TAG_W-1:0]          lk_tag_o,
  output logic [1:0]                lk_state_o,
  input  logic [$clog2(BEATS)-1:0]  rd_beat_i,
  output logic [DATA_W-1:0]         rd_data_o,
  input  logic                      inv_en_i,
  input  logic                      tp_we_i,
  input  logic                      tp_dwe_i,
  input  logic [$clog2(LINES)-1:0]  tp_idx_i,
  input  logic [$clog2(BEATS)-1:0]  tp_beat_i,
  input  logic [TAG_W-1:0]          tp_tag_i,
  input  logic [1:0]                tp_state_i,
  input  logic [DATA_W-1:0]         tp_data_i,
  output logic [TAG_W-1:0]          tp_rd_tag_o,
  output logic [1:0]                tp_rd_state_o
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int BEAT_W = $clog2(BEATS);

  logic [TAG_W-1:0]  tags   [LINES];
  logic [1:0]        states [LINES];
  logic [DATA_W-1:0] words  [LINES*BEATS];

  // One state/tag register set per line; a snoop invalidate outranks a test write.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        states[g] <= ST_INV;
        tags[g]   <= '0;
      end else if (inv_en_i && lk_idx_i == IDX_W'(g)) begin
        states[g] <= ST_INV;
      end else if (tp_we_i && tp_idx_i == IDX_W'(g)) begin
        states[g] <= tp_state_i;
        tags[g]   <= tp_tag_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tp_dwe_i) words[{tp_idx_i, tp_beat_i}] <= tp_data_i;
  end

  assign lk_tag_o      = tags[lk_idx_i];
  assign lk_state_o    = states[lk_idx_i];
  assign rd_data_o     = words[{lk_idx_i, rd_beat_i}];
  assign tp_rd_tag_o   = tags[tp_idx_i];
  assign tp_rd_state_o = states[tp_idx_i];

  logic [BEAT_W-1:0] unused_beat_w;
  assign unused_beat_w = '0;
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 16
) (
  input  logic                                                   clk,
  input  logic                                                   rst_n,
  input  logic                                                   snoop_en,
  input  logic                                                   req_valid,
  output logic                                                   req_ready,
  input  logic [ADDR_W-1:0]                                      req_addr,
  input  logic                                                   req_burst,
  input  logic                                                   req_lock,
  output logic                                                   snp_valid,
  output logic [1:0]                                             snp_kind,
  output logic [ADDR_W-1:0]                                      snp_addr,
  output logic                                                   snp_flush,
  output logic                                                   done,
  output logic                                                   retry,
  output logic                                                   wb_valid,
  input  logic                                                   wb_ready,
  output logic [ADDR_W-1:0]                                      wb_addr,
  output logic [DATA_W-1:0]                                      wb_data,
  output logic                                                   wb_last,
  input  logic                                                   tp_we,
  input  logic                                                   tp_dwe,
  input  logic [$clog2(LINES)-1:0]                               tp_index,
  input  logic [$clog2(LINE_BYTES*8/DATA_W)-1:0]                 tp_beat,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-1:0]     tp_tag,
  input  logic [1:0]                                             tp_state,
  input  logic [DATA_W-1:0]                                      tp_data,
  output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-1:0]     tp_rd_tag,
  output logic [1:0]                                             tp_rd_state
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BEATS  = LINE_BYTES * 8 / DATA_W;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int BYTE_W = $clog2(DATA_W / 8);

  fsm_e              fsm_q, fsm_d;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        kind_q;
  logic              flush_q;
  logic              en_q;

  logic [1:0]        map_kind;
  logic              map_flush;
  logic              accept;

  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [TAG_W-1:0]  lk_tag;
  logic [1:0]        lk_state;
  logic [1:0]        hit_state;
  logic [DATA_W-1:0] rd_data;
  logic [BEAT_W-1:0] beat;
  logic              beat_last;
  logic              beat_clr, beat_adv;
  logic              inv_en;

  snp_cmd_map u_map (
    .lock_i     (req_lock),
    .burst_i    (req_burst),
    .kind_o     (map_kind),
    .as_write_o (map_flush)
  );

  assign accept  = req_valid && req_ready;
  assign cur_idx = addr_q[OFF_W +: IDX_W];
  assign cur_tag = addr_q[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q   <= F_IDLE;
      addr_q  <= '0;
      kind_q  <= KIND_READ;
      flush_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      fsm_q <= fsm_d;
      if (accept) begin
        addr_q  <= req_addr;
        kind_q  <= map_kind;
        flush_q <= map_flush;
        en_q    <= snoop_en;
      end
    end
  end

  snp_line_store #(
    .LINES  (LINES),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W),
    .BEATS  (BEATS)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_idx_i      (cur_idx),
    .lk_tag_o      (lk_tag),
    .lk_state_o    (lk_state),
    .rd_beat_i     (beat),
    .rd_data_o     (rd_data),
    .inv_en_i      (inv_en),
    .tp_we_i       (tp_we),
    .tp_dwe_i      (tp_dwe),
    .tp_idx_i      (tp_index),
    .tp_beat_i     (tp_beat),
    .tp_tag_i      (tp_tag),
    .tp_state_i    (tp_state),
    .tp_data_i     (tp_data),
    .tp_rd_tag_o   (tp_rd_tag),
    .tp_rd_state_o (tp_rd_state)
  );

  snp_beat_ctr #(.BEATS(BEATS)) u_beats (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (beat_clr),
    .adv_i  (beat_adv),
    .beat_o (beat),
    .last_o (beat_last)
  );

  // A tag mismatch is the same as an invalid line; 2'b11 is also treated as invalid.
  always_comb begin
    hit_state = ST_INV;
    if (lk_tag == cur_tag && (lk_state == ST_EXCL || lk_state == ST_MOD))
      hit_state = lk_state;
  end

  always_comb begin
    fsm_d    = fsm_q;
    done     = 1'b0;
    inv_en   = 1'b0;
    beat_clr = 1'b0;
    beat_adv = 1'b0;
    unique case (fsm_q)
      F_IDLE: begin
        if (accept) fsm_d = F_LOOK;
      end
      F_LOOK: begin
        beat_clr = 1'b1;
        if (en_q && hit_state == ST_MOD) begin
          fsm_d = F_FLUSH;
        end else begin
          done   = 1'b1;
          inv_en = en_q && (hit_state == ST_EXCL);
          fsm_d  = F_IDLE;
        end
      end
      F_FLUSH: begin
        if (wb_ready) begin
          beat_adv = 1'b1;
          if (beat_last) begin
            done   = 1'b1;
            inv_en = 1'b1;
            fsm_d  = F_IDLE;
          end
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  assign req_ready = (fsm_q == F_IDLE);
  assign snp_valid = (fsm_q == F_LOOK) && en_q;
  assign snp_kind  = kind_q;
  assign snp_addr  = addr_q;
  assign snp_flush = flush_q;
  assign retry     = (fsm_q == F_FLUSH);
  assign wb_valid  = (fsm_q == F_FLUSH);
  assign wb_addr   = {cur_tag, cur_idx, beat, {BYTE_W{1'b0}}};
  assign wb_data   = rd_data;
  assign wb_last   = beat_last;
endmodule

// File: rtl/snp_checker.sv
module snp_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoop_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_lock,
  input logic              snp_valid,
  input logic [1:0]        snp_kind,
  input logic              done,
  input logic              retry,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [DATA_W-1:0] wb_data,
  input logic              wb_last
);
  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !req_ready);

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_read_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && snoop_en && !req_lock) |=> (snp_valid && snp_kind == 2'b01));

  assert_lock_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && snoop_en && req_lock) |=> (snp_valid && snp_kind == 2'b10));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !snoop_en) |=> (!snp_valid && done && !wb_valid));

  assert_wb_under_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> retry);

  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data) && $stable(wb_last)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind snoop_responder snp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .snoop_en  (snoop_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_lock  (req_lock),
  .snp_valid (snp_valid),
  .snp_kind  (snp_kind),
  .done      (done),
  .retry     (retry),
  .wb_valid  (wb_valid),
  .wb_ready  (wb_ready),
  .wb_addr   (wb_addr),
  .wb_data   (wb_data),
  .wb_last   (wb_last)
);

// File: tb/snoop_responder_test.sv
`timescale 1ns/1ps
module snoop_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snoop_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_burst = 1'b0;
  logic        req_lock = 1'b0;
  logic        snp_valid;
  logic [1:0]  snp_kind;
  logic [31:0] snp_addr;
  logic        snp_flush;
  logic        done, retry;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic [31:0] wb_addr;
  logic [63:0] wb_data;
  logic        wb_last;
  logic        tp_we = 1'b0, tp_dwe = 1'b0;
  logic [3:0]  tp_index = '0;
  logic [1:0]  tp_beat = '0;
  logic [22:0] tp_tag = '0;
  logic [1:0]  tp_state = '0;
  logic [63:0] tp_data = '0;
  logic [22:0] tp_rd_tag;
  logic [1:0]  tp_rd_state;

  int n_checks = 0;
  int n_fail = 0;

  logic [22:0] m_tag  [16];
  logic [1:0]  m_st   [16];
  logic [63:0] m_data [16][4];

  always #4 clk = ~clk;

  snoop_responder uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [22:0] tag, input logic [3:0] idx,
                                          input logic [4:0] off);
    return {tag, idx, off};
  endfunction

  function automatic bit exp_wb(input logic [3:0] idx, input logic [22:0] tag, input bit en);
    return en && m_st[idx] == 2'b10 && m_tag[idx] == tag;
  endfunction

  function automatic bit exp_inv(input logic [3:0] idx, input logic [22:0] tag, input bit en);
    return en && (m_st[idx] == 2'b10 || m_st[idx] == 2'b01) && m_tag[idx] == tag;
  endfunction

  task automatic preload(input logic [3:0] idx, input logic [22:0] tag, input logic [1:0] st);
    @(negedge clk);
    tp_we = 1'b1; tp_index = idx; tp_tag = tag; tp_state = st;
    @(negedge clk);
    tp_we = 1'b0;
    m_tag[idx] = tag; m_st[idx] = st;
    for (int b = 0; b < 4; b++) begin
      m_data[idx][b] = {$urandom, $urandom};
      tp_dwe = 1'b1; tp_beat = 2'(b); tp_data = m_data[idx][b];
      @(negedge clk);
    end
    tp_dwe = 1'b0;
  endtask

  task automatic snoop(input logic [3:0] idx, input logic [22:0] tag, input bit burst,
                       input bit lock, input bit en, input int stall_pct);
    logic [31:0] a;
    bit wb, inv;
    int beat, guard;
    logic [31:0] held_a;
    logic [63:0] held_d;
    bit stalled;
    a = mk_addr(tag, idx, 5'($urandom));
    wb = exp_wb(idx, tag, en);
    inv = exp_inv(idx, tag, en);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a; req_burst = burst; req_lock = lock; snoop_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready after accept", 64'(req_ready), 64'd0);
    if (en) begin
      chk(snp_valid == 1'b1, "R3", "snoop valid", 64'(snp_valid), 64'd1);
      if (lock) chk(snp_kind == 2'b10, "R4", "locked kind", 64'(snp_kind), 64'd2);
      else      chk(snp_kind == 2'b01, "R3", "plain kind", 64'(snp_kind), 64'd1);
      chk(snp_addr == a, "R3", "snoop addr", 64'(snp_addr), 64'(a));
      chk(snp_flush == burst, "R3", "flush flag", 64'(snp_flush), 64'(burst));
    end else begin
      chk(snp_valid == 1'b0, "R5", "no snoop when disabled", 64'(snp_valid), 64'd0);
    end
    if (!wb) begin
      chk(done == 1'b1, inv ? "R7" : (en ? "R6" : "R5"), "done in snoop cycle", 64'(done), 64'd1);
      chk(wb_valid == 1'b0, "R6", "no write-back", 64'(wb_valid), 64'd0);
    end else begin
      chk(done == 1'b0, "R8", "no done before write-back", 64'(done), 64'd0);
      @(negedge clk);
      beat = 0; guard = 0; stalled = 0; held_a = '0; held_d = '0;
      while (beat < 4 && guard < 200) begin
        guard++;
        wb_ready = (($urandom % 100) >= 32'(stall_pct));
        #1;
        chk(wb_valid == 1'b1 && retry == 1'b1, "R8", "valid+retry in flush",
            64'({wb_valid, retry}), 64'd3);
        chk(req_ready == 1'b0, "R2", "ready low in flush", 64'(req_ready), 64'd0);
        if (stalled) begin
          chk(wb_addr == held_a && wb_data == held_d, "R9", "held beat", wb_data, held_d);
        end
        chk(wb_addr == mk_addr(tag, idx, {2'(beat), 3'b000}), "R8", "beat addr",
            64'(wb_addr), 64'(mk_addr(tag, idx, {2'(beat), 3'b000})));
        chk(wb_data == m_data[idx][beat], "R8", "beat data", wb_data, m_data[idx][beat]);
        chk(wb_last == (beat == 3), "R8", "last flag", 64'(wb_last), 64'(beat == 3));
        chk(done == (wb_ready && beat == 3), "R8", "done on final beat", 64'(done),
            64'(wb_ready && beat == 3));
        stalled = !wb_ready; held_a = wb_addr; held_d = wb_data;
        @(posedge clk);
        if (wb_ready) beat++;
        @(negedge clk);
      end
      wb_ready = 1'b0;
      chk(beat == 4, "R8", "all beats taken", 64'(beat), 64'd4);
    end
    if (!wb) @(negedge clk);
    chk(done == 1'b0, "R10", "done is one cycle", 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R2", "ready after done", 64'(req_ready), 64'd1);
    if (inv) m_st[idx] = 2'b00;
    tp_index = idx;
    #1;
    chk(tp_rd_state == m_st[idx], wb ? "R8" : (inv ? "R7" : "R6"), "line state after snoop",
        64'(tp_rd_state), 64'(m_st[idx]));
    snoop_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      m_st[i] = 2'b00; m_tag[i] = '0;
      for (int b = 0; b < 4; b++) m_data[i][b] = '0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && snp_valid == 1'b0 && done == 1'b0 && retry == 1'b0 && wb_valid == 1'b0,
        "R1", "outputs in reset", 64'({req_ready, snp_valid, done, retry, wb_valid}), 64'h10);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      tp_index = 4'(i); #1;
      chk(tp_rd_state == 2'b00, "R1", "line invalid after reset", 64'(tp_rd_state), 64'd0);
    end

    // R11: test-port write and read-back
    preload(4'd3, 23'h12345, 2'b01);
    tp_index = 4'd3; #1;
    chk(tp_rd_tag == 23'h12345 && tp_rd_state == 2'b01, "R11", "test port readback",
        64'({tp_rd_tag, tp_rd_state}), 64'({23'h12345, 2'b01}));

    // Directed corners
    snoop(4'd3, 23'h00001, 1'b0, 1'b0, 1'b1, 0);   // R6 tag mismatch on exclusive
    snoop(4'd5, 23'h00777, 1'b1, 1'b0, 1'b1, 0);   // R6 invalid line
    snoop(4'd3, 23'h12345, 1'b0, 1'b0, 1'b1, 0);   // R7 exclusive, plain read
    preload(4'd4, 23'h0abcd, 2'b01);
    snoop(4'd4, 23'h0abcd, 1'b1, 1'b1, 1'b1, 0);   // R7/R4 exclusive, locked
    preload(4'd7, 23'h7ffff, 2'b10);
    snoop(4'd7, 23'h7ffff, 1'b1, 1'b1, 1'b0, 0);   // R5 disabled on modified line
    snoop(4'd7, 23'h7ffff, 1'b0, 1'b0, 1'b1, 0);   // R8 modified, no stall
    preload(4'd15, 23'h40000, 2'b10);
    snoop(4'd15, 23'h40000, 1'b1, 1'b1, 1'b1, 70); // R8/R9/R4 modified with stalls

    // Constrained random mix
    for (int i = 0; i < 16; i++) preload(4'(i), 23'($urandom), 2'($urandom % 3));
    for (int n = 0; n < 80; n++) begin
      logic [3:0] idx;
      logic [22:0] tag;
      idx = 4'($urandom);
      if (($urandom % 4) == 0) preload(idx, 23'($urandom), 2'($urandom % 3));
      tag = (($urandom % 5) == 0) ? 23'($urandom) : m_tag[idx];
      snoop(idx, tag, 1'($urandom), 1'($urandom), (($urandom % 6) != 0), 40);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule